// File: doc/BRIEF.md
# Network Controller Host Register Front End

This block is the bus slave that a host processor uses to drive a network controller. It decodes four word registers: control/status, DMA bus address, DMA byte count and an optional address extension. A host write of a non-zero function code into the control/status register, made while the controller is idle, launches one command toward the command backend. That launch is a single-cycle strobe carrying the code, the byte count and the full DMA address. The block then holds a busy state until the backend reports completion with a status code.

Two event flags, command-done and receive-DMA-done, are kept in the control/status register. Each is gated by its own enable to form an interrupt request, and each request has its own vector. A read of the control/status register returns the flags and clears them. A strap input chooses where the upper DMA address bits come from: a two-bit field in the control/status register (18-bit addressing), or a separate six-bit extension register (22-bit addressing).

Top module: `nhr_host_regs`

## Requirements
- R1: After a synchronous reset every register reads zero, `cmd_busy`, `cmd_stb`, both interrupt requests and `irq_vec` are low, and `bus_rdata` is zero.
- R2: `bus_off` selects a word register: 0 control/status, 1 bus address, 2 byte count, 3 address extension. Read data appears on `bus_rdata` in the cycle after the read, and the bus address and byte count read back what was last written.
- R3: Control/status layout: bits 3:0 status code, 5:4 extended-address bits 17:16, 6 command-done interrupt enable, 7 receive-done interrupt enable, 13:8 function code, 14 receive-DMA-done flag, 15 command-done flag.
- R4: A control/status write with a non-zero function code while idle sets `cmd_busy` and, in the cycle after the write, raises `cmd_stb` for exactly one cycle with `cmd_func`, `cmd_count` and `cmd_addr` valid. A write with function code 0 updates the fields without a strobe.
- R5: While `cmd_busy` is high, a control/status write is ignored completely: no field changes and no strobe.
- R6: A `cmpl_stb` pulse stores `cmpl_code` in bits 3:0, clears `cmd_busy` and sets the command-done flag.
- R7: A `rx_done_stb` pulse sets the receive-DMA-done flag.
- R8: A control/status read returns the value held before the read and clears both done flags. A done event in the same cycle as the read leaves its flag set.
- R9: Writes to bits 15:14 and 3:0 of the control/status register have no effect.
- R10: `irq_cmd` is high exactly while the command-done flag and its enable are both set, and `irq_rx` likewise for the receive flag and its enable.
- R11: `irq_vec` is `VEC_BASE` when `irq_rx` is high, `VEC_BASE`+4 when only `irq_cmd` is high, and 0 when neither is high.
- R12: With `ext_en` high, `cmd_addr` is {extension[5:0], bus address}, and the control/status bits 5:4 play no part in it.
- R13: With `ext_en` low, `cmd_addr` is {4'b0, CSR bits 5:4 as written in the launching write, bus address}. Offset 3 reads zero and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Strap: extension register present |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_off | input | 2 | Word register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cmd_stb | output | 1 | One-cycle command launch |
| cmd_func | output | 6 | Launched function code |
| cmd_addr | output | 22 | Launched DMA address |
| cmd_count | output | 16 | Launched byte count |
| cmd_busy | output | 1 | Command in progress |
| cmpl_stb | input | 1 | Backend completion pulse |
| cmpl_code | input | 4 | Completion status code |
| rx_done_stb | input | 1 | Receive DMA completion pulse |
| irq_rx | output | 1 | Receive-done interrupt request |
| irq_cmd | output | 1 | Command-done interrupt request |
| irq_vec | output | VEC_W | Vector of the highest-priority request |

## Verification
The properties assume that the host never reads and writes in the same cycle, and that the backend pulses `cmpl_stb` only while `cmd_busy` is high. Under that assumption a completion never coincides with an accepted launch. The stimulus follows both rules: each random cycle selects at most one bus operation, and completions are drawn only when the bench's own model reports a command in progress. The strap changes only between cycles, and the narrow-address property compares the launch against the strap value sampled on the launching edge.

// File: rtl/nhr_pkg.sv
package nhr_pkg;
  localparam int WORD_W  = 16;
  localparam int FUNC_W  = 6;
  localparam int STAT_W  = 4;
  localparam int XM_W    = 2;
  localparam int EXT_W   = 6;
  localparam int OFF_W   = 2;
  localparam int ADDR_W  = WORD_W + EXT_W;

  // control/status bit positions
  localparam int CS_STAT_LO = 0;
  localparam int CS_XM_LO   = CS_STAT_LO + STAT_W;
  localparam int CS_CIE     = CS_XM_LO + XM_W;
  localparam int CS_RIE     = CS_CIE + 1;
  localparam int CS_FUNC_LO = CS_RIE + 1;
  localparam int CS_RXD     = CS_FUNC_LO + FUNC_W;
  localparam int CS_CMDD    = CS_RXD + 1;

  typedef enum logic [OFF_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_BADDR = 2'd1,
    REG_BCNT  = 2'd2,
    REG_AEXT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/nhr_addr_form.sv
module nhr_addr_form
  import nhr_pkg::*;
(
  input  logic              ext_en,
  input  logic [WORD_W-1:0] base,
  input  logic [XM_W-1:0]   xm,
  input  logic [EXT_W-1:0]  ext,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - WORD_W - XM_W;

  logic [ADDR_W-1:0] wide_addr;
  logic [ADDR_W-1:0] narrow_addr;

  assign wide_addr = {ext, base};

  generate
    if (PAD_W > 0) begin : g_pad
      assign narrow_addr = {{PAD_W{1'b0}}, xm, base};
    end else begin : g_nopad
      assign narrow_addr = {xm, base};
    end
  endgenerate

  always_comb begin
    if (ext_en) addr = wide_addr;
    else        addr = narrow_addr;
  end
endmodule

// File: rtl/nhr_cmd_ctl.sv
module nhr_cmd_ctl
  import nhr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [FUNC_W-1:0] w_func,
  input  logic [XM_W-1:0]   w_xm,
  input  logic              w_cie,
  input  logic              w_rie,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WORD_W-1:0] count_in,
  input  logic              cmpl,
  input  logic [STAT_W-1:0] cmpl_code,
  input  logic              rx_evt,
  output logic [WORD_W-1:0] csr_val,
  output logic [XM_W-1:0]   xm_q,
  output logic              cie_q,
  output logic              rie_q,
  output logic              cmdd_q,
  output logic              rxd_q,
  output logic              busy_q,
  output logic              stb_q,
  output logic [FUNC_W-1:0] stb_func,
  output logic [ADDR_W-1:0] stb_addr,
  output logic [WORD_W-1:0] stb_count
);
  logic [FUNC_W-1:0] func_q;
  logic [STAT_W-1:0] stat_q;
  logic              wr_ok;
  logic              launch;

  assign wr_ok  = csr_wr && !busy_q;
  assign launch = wr_ok && (w_func != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q    <= '0;
      stat_q    <= '0;
      xm_q      <= '0;
      cie_q     <= 1'b0;
      rie_q     <= 1'b0;
      cmdd_q    <= 1'b0;
      rxd_q     <= 1'b0;
      busy_q    <= 1'b0;
      stb_q     <= 1'b0;
      stb_func  <= '0;
      stb_addr  <= '0;
      stb_count <= '0;
    end else begin
      stb_q <= launch;
      if (launch) begin
        stb_func  <= w_func;
        stb_addr  <= addr_in;
        stb_count <= count_in;
      end
      if (wr_ok) begin
        func_q <= w_func;
        xm_q   <= w_xm;
        cie_q  <= w_cie;
        rie_q  <= w_rie;
      end
      if (launch)    busy_q <= 1'b1;
      else if (cmpl) busy_q <= 1'b0;
      if (cmpl) stat_q <= cmpl_code;
      // a fresh event wins over the clear-on-read
      if (cmpl)        cmdd_q <= 1'b1;
      else if (csr_rd) cmdd_q <= 1'b0;
      if (rx_evt)      rxd_q  <= 1'b1;
      else if (csr_rd) rxd_q  <= 1'b0;
    end
  end

  always_comb begin
    csr_val = '0;
    csr_val[CS_STAT_LO +: STAT_W] = stat_q;
    csr_val[CS_XM_LO +: XM_W]     = xm_q;
    csr_val[CS_CIE]               = cie_q;
    csr_val[CS_RIE]               = rie_q;
    csr_val[CS_FUNC_LO +: FUNC_W] = func_q;
    csr_val[CS_RXD]               = rxd_q;
    csr_val[CS_CMDD]              = cmdd_q;
  end
endmodule

// File: rtl/nhr_irq.sv
module nhr_irq #(
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o140
) (
  input  logic             cmdd,
  input  logic             rxd,
  input  logic             cie,
  input  logic             rie,
  output logic             irq_cmd,
  output logic             irq_rx,
  output logic [VEC_W-1:0] vec
);
  localparam logic [VEC_W-1:0] VEC_CMD = VEC_BASE + VEC_W'(4);

  assign irq_cmd = cmdd && cie;
  assign irq_rx  = rxd && rie;

  always_comb begin
    if (irq_rx)       vec = VEC_BASE;
    else if (irq_cmd) vec = VEC_CMD;
    else              vec = '0;
  end
endmodule

// File: rtl/nhr_host_regs.sv
module nhr_host_regs
  import nhr_pkg::*;
#(
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o140
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              cmd_stb,
  output logic [FUNC_W-1:0] cmd_func,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_count,
  output logic              cmd_busy,
  input  logic              cmpl_stb,
  input  logic [STAT_W-1:0] cmpl_code,
  input  logic              rx_done_stb,
  output logic              irq_rx,
  output logic              irq_cmd,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [WORD_W-1:0] bar_q;
  logic [WORD_W-1:0] bcr_q;
  logic [EXT_W-1:0]  ext_q;
  logic [WORD_W-1:0] csr_val;
  logic [XM_W-1:0]   xm_q;
  logic [XM_W-1:0]   xm_src;
  logic [ADDR_W-1:0] formed;
  logic              cie_q, rie_q, cmdd_q, rxd_q;
  logic              wr_any, rd_any, csr_wr, csr_rd;

  assign wr_any = bus_sel && bus_wr;
  assign rd_any = bus_sel && bus_rd;
  assign csr_wr = wr_any && (bus_off == REG_CTRL);
  assign csr_rd = rd_any && (bus_off == REG_CTRL);

  // the launching write supplies its own extended-address bits
  assign xm_src = csr_wr ? bus_wdata[CS_XM_LO +: XM_W] : xm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_q <= '0;
      bcr_q <= '0;
      ext_q <= '0;
    end else if (wr_any) begin
      case (bus_off)
        REG_BADDR: bar_q <= bus_wdata;
        REG_BCNT:  bcr_q <= bus_wdata;
        REG_AEXT:  if (ext_en) ext_q <= bus_wdata[EXT_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      case (bus_off)
        REG_CTRL:  bus_rdata <= csr_val;
        REG_BADDR: bus_rdata <= bar_q;
        REG_BCNT:  bus_rdata <= bcr_q;
        default:   bus_rdata <= ext_en ? {{(WORD_W-EXT_W){1'b0}}, ext_q} : '0;
      endcase
    end
  end

  nhr_addr_form u_addr (
    .ext_en (ext_en),
    .base   (bar_q),
    .xm     (xm_src),
    .ext    (ext_q),
    .addr   (formed)
  );

  nhr_cmd_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .w_func    (bus_wdata[CS_FUNC_LO +: FUNC_W]),
    .w_xm      (bus_wdata[CS_XM_LO +: XM_W]),
    .w_cie     (bus_wdata[CS_CIE]),
    .w_rie     (bus_wdata[CS_RIE]),
    .addr_in   (formed),
    .count_in  (bcr_q),
    .cmpl      (cmpl_stb),
    .cmpl_code (cmpl_code),
    .rx_evt    (rx_done_stb),
    .csr_val   (csr_val),
    .xm_q      (xm_q),
    .cie_q     (cie_q),
    .rie_q     (rie_q),
    .cmdd_q    (cmdd_q),
    .rxd_q     (rxd_q),
    .busy_q    (cmd_busy),
    .stb_q     (cmd_stb),
    .stb_func  (cmd_func),
    .stb_addr  (cmd_addr),
    .stb_count (cmd_count)
  );

  nhr_irq #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_irq (
    .cmdd    (cmdd_q),
    .rxd     (rxd_q),
    .cie     (cie_q),
    .rie     (rie_q),
    .irq_cmd (irq_cmd),
    .irq_rx  (irq_rx),
    .vec     (irq_vec)
  );
endmodule

// File: rtl/nhr_host_regs_chk.sv
module nhr_host_regs_chk #(
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o140
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_en,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_off,
  input logic             cmd_stb,
  input logic [3:0]       addr_top,
  input logic             cmd_busy,
  input logic             cmpl_stb,
  input logic             rx_done_stb,
  input logic             irq_rx,
  input logic             irq_cmd,
  input logic [VEC_W-1:0] irq_vec
);
  p_stb_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);

  p_stb_from_idle_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> (cmd_busy && !$past(cmd_busy)));

  p_busy_write_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_off == 2'd0 && cmd_busy) |=> !cmd_stb);

  p_cmpl_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (cmpl_stb && cmd_busy) |=> !cmd_busy);

  p_read_quiets_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_rd && bus_off == 2'd0 && !cmpl_stb) |=> !irq_cmd);

  p_read_quiets_rx_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_rd && bus_off == 2'd0 && !rx_done_stb) |=> !irq_rx);

  p_rx_vector_r11: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> (irq_vec == VEC_BASE));

  p_narrow_addr_r13: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !$past(ext_en)) |-> (addr_top == 4'd0));
endmodule

bind nhr_host_regs nhr_host_regs_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ext_en      (ext_en),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_off     (bus_off),
  .cmd_stb     (cmd_stb),
  .addr_top    (cmd_addr[21:18]),
  .cmd_busy    (cmd_busy),
  .cmpl_stb    (cmpl_stb),
  .rx_done_stb (rx_done_stb),
  .irq_rx      (irq_rx),
  .irq_cmd     (irq_cmd),
  .irq_vec     (irq_vec)
);

// File: tb/sim_nhr_host_regs.sv
module sim_nhr_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] VB = 9'o140;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_en = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_off = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cmd_stb, cmd_busy, irq_rx, irq_cmd;
  logic [5:0]  cmd_func;
  logic [21:0] cmd_addr;
  logic [15:0] cmd_count;
  logic        cmpl_stb = 1'b0, rx_done_stb = 1'b0;
  logic [3:0]  cmpl_code = '0;
  logic [8:0]  irq_vec;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench model
  logic [15:0] m_bar, m_bcr;
  logic [5:0]  m_ext, m_func;
  logic [1:0]  m_xm;
  logic        m_cie, m_rie, m_cd, m_rd, m_busy;
  logic [3:0]  m_stat;
  logic [15:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  nhr_host_regs u0 (
    .clk(clk), .rst(rst), .ext_en(ext_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_stb(cmd_stb), .cmd_func(cmd_func), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .cmd_busy(cmd_busy), .cmpl_stb(cmpl_stb), .cmpl_code(cmpl_code),
    .rx_done_stb(rx_done_stb), .irq_rx(irq_rx), .irq_cmd(irq_cmd), .irq_vec(irq_vec)
  );

  function automatic logic [15:0] csr_model();
    return {m_cd, m_rd, m_func, m_rie, m_cie, m_xm, m_stat};
  endfunction

  function automatic logic [21:0] addr_model(input logic [1:0] xm);
    return ext_en ? {m_ext, m_bar} : {4'b0, xm, m_bar};
  endfunction

  function automatic logic [8:0] vec_model();
    if (m_rd && m_rie) return VB;
    if (m_cd && m_cie) return VB + 9'd4;
    return 9'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus/backend cycle with full model update and checks
  task automatic cyc(input logic rd, input logic wr, input logic [1:0] off,
                     input logic [15:0] d, input logic cp, input logic [3:0] code,
                     input logic rx);
    logic [15:0] exp_rd;
    logic        launch;
    logic [21:0] exp_addr;
    logic [5:0]  exp_func;
    logic [15:0] exp_cnt;
    @(negedge clk);
    bus_sel = rd | wr; bus_rd = rd; bus_wr = wr; bus_off = off; bus_wdata = d;
    cmpl_stb = cp; cmpl_code = code; rx_done_stb = rx;
    case (off)
      2'd0: exp_rd = csr_model();
      2'd1: exp_rd = m_bar;
      2'd2: exp_rd = m_bcr;
      default: exp_rd = ext_en ? {10'b0, m_ext} : 16'h0;
    endcase
    launch = wr && off == 2'd0 && !m_busy && d[13:8] != 6'd0;
    exp_addr = addr_model(d[5:4]);
    exp_func = d[13:8];
    exp_cnt = m_bcr;
    // model update
    if (wr && off == 2'd1) m_bar = d;
    if (wr && off == 2'd2) m_bcr = d;
    if (wr && off == 2'd3 && ext_en) m_ext = d[5:0];
    if (wr && off == 2'd0 && !m_busy) begin
      m_func = d[13:8]; m_xm = d[5:4]; m_cie = d[6]; m_rie = d[7];
    end
    if (launch) m_busy = 1'b1;
    else if (cp) m_busy = 1'b0;
    if (cp) m_stat = code;
    if (cp) m_cd = 1'b1; else if (rd && off == 2'd0) m_cd = 1'b0;
    if (rx) m_rd = 1'b1; else if (rd && off == 2'd0) m_rd = 1'b0;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_rd = 0; bus_wr = 0; cmpl_stb = 0; rx_done_stb = 0;
    if (rd) begin
      got = bus_rdata;
      if (off == 2'd0)      chk("R8 csr read", bus_rdata, exp_rd);
      else if (off == 2'd3) chk("R13 ext read", bus_rdata, exp_rd);
      else                  chk("R2 reg read", bus_rdata, exp_rd);
    end
    chk("R4 strobe", cmd_stb, launch);
    if (launch) begin
      chk("R4 func", cmd_func, exp_func);
      chk("R4 count", cmd_count, exp_cnt);
      if (ext_en) chk("R12 wide addr", cmd_addr, exp_addr);
      else        chk("R13 narrow addr", cmd_addr, exp_addr);
    end
    chk("R6 busy", cmd_busy, m_busy);
    chk("R10 irq cmd", irq_cmd, m_cd & m_cie);
    chk("R10 irq rx", irq_rx, m_rd & m_rie);
    chk("R11 vector", irq_vec, vec_model());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    m_bar = 0; m_bcr = 0; m_ext = 0; m_func = 0; m_xm = 0; m_cie = 0; m_rie = 0;
    m_cd = 0; m_rd = 0; m_busy = 0; m_stat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 busy", cmd_busy, 1'b0);
    chk("R1 irq", {irq_rx, irq_cmd, cmd_stb}, 3'b000);
    chk("R1 rdata", bus_rdata, 16'h0);
    cyc(1, 0, 2'd0, 0, 0, 0, 0);
    chk("R1 csr", got, 16'h0);
    // R9 read-only bits ignored
    cyc(0, 1, 2'd0, 16'hC00F, 0, 0, 0);
    cyc(1, 0, 2'd0, 0, 0, 0, 0);
    chk("R9 ro bits", got, 16'h0000);
    // R13 narrow: extension register absent
    cyc(0, 1, 2'd3, 16'h003F, 0, 0, 0);
    cyc(1, 0, 2'd3, 0, 0, 0, 0);
    chk("R13 ext absent", got, 16'h0);
    cyc(0, 1, 2'd1, 16'h1234, 0, 0, 0);
    cyc(0, 1, 2'd2, 16'h0200, 0, 0, 0);
    // R3 layout: func 04, rie, cie, xm=3
    cyc(0, 1, 2'd0, 16'h04F0, 0, 0, 0);
    chk("R13 addr with xm", cmd_addr, 22'h031234);
    cyc(1, 0, 2'd0, 0, 0, 0, 0);
    chk("R3 layout", got, 16'h04F0);
    // R5 write while busy
    cyc(0, 1, 2'd0, 16'h2800, 0, 0, 0);
    chk("R5 no strobe", cmd_stb, 1'b0);
    cyc(1, 0, 2'd0, 0, 0, 0, 0);
    chk("R5 csr kept", got, 16'h04F0);
    // R6 completion with code 016 octal
    cyc(0, 0, 2'd0, 0, 1, 4'hE, 0);
    chk("R6 irq", irq_cmd, 1'b1);
    chk("R11 cmd vector", irq_vec, VB + 9'd4);
    // R7 receive flag, R11 priority
    cyc(0, 0, 2'd0, 0, 0, 0, 1);
    chk("R7 irq rx", irq_rx, 1'b1);
    chk("R11 rx first", irq_vec, VB);
    // R8 read with simultaneous rx event
    cyc(1, 0, 2'd0, 0, 0, 0, 1);
    chk("R8 pre value", got, 16'hC4FE);
    chk("R8 rx kept", irq_rx, 1'b1);
    chk("R8 cmd cleared", irq_cmd, 1'b0);
    cyc(1, 0, 2'd0, 0, 0, 0, 0);
    chk("R8 second read", got, 16'h44FE);
    // R12 wide addressing ignores xm
    ext_en = 1'b1;
    cyc(0, 1, 2'd3, 16'hFF2A, 0, 0, 0);
    cyc(0, 1, 2'd0, 16'h1130, 0, 0, 0);
    chk("R12 ext addr", cmd_addr, 22'h2A1234);
    cyc(0, 0, 2'd0, 0, 1, 4'h1, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [1:0] off;
      logic [15:0] d;
      logic cp, rx;
      if (i % 500 == 0) begin @(negedge clk); ext_en = $urandom % 2; end
      op = $urandom % 8;
      off = 2'($urandom % 4);
      d = 16'($urandom);
      if ($urandom % 3 == 0) d[13:8] = 6'd0;
      cp = m_busy && ($urandom % 4 == 0);
      rx = ($urandom % 6 == 0);
      if (op < 2)      cyc(1, 0, off, 0, cp, 4'($urandom), rx);
      else if (op == 2) cyc(0, 1, 2'd0, d, cp, 4'($urandom), rx);
      else if (op < 6) cyc(0, 1, 2'(1 + $urandom % 3), d, cp, 4'($urandom), rx);
      else             cyc(0, 0, off, 0, cp, 4'($urandom), rx);
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule